// File: doc/BRIEF.md
# Serial Instruction Front End for a Word-Organised Protected Memory

This block is the slave end of a three-wire serial link: a select line, a serial clock and a data input, plus a data output with a separate enable. It runs on a faster system clock and oversamples the serial pins. It waits for a start bit, then collects a two-bit operation code and an eight-bit address field. It collects sixteen data bits when the instruction needs them. It decodes the instruction against the level of the protect-select pin. The result goes out as one-cycle strobes to a protect controller and a programming sequencer elsewhere on the chip.

Instructions that need no timed cycle are issued as soon as their last bit arrives. Programming instructions are held and issued only when the select line falls. Reads stream memory words, or the protect address, out on the data output after a leading zero bit. Once a programming instruction has been committed, raising the select line again shows the sequencer's ready state on the data output. The memory array, the protection rules and the cycle timing sit outside this block.

Top module: `mw_serial_front`

## Requirements
- R1: No instruction starts until a serial clock rising edge finds both select and data input high. Clock edges with data input low, and any edges while select is low, start nothing and issue no strobe.
- R2: With protect-select low, the operation code decodes as follows. 10 is read (code 11). 01 is write (code 4). 11 is erase (code 3). For 00, address bits 7:6 choose enable (11, code 1), erase-all (10, code 5), write-all (01, code 6) or disable (00, code 2).
- R3: With protect-select high, the decode is as follows. 10 is protect-read (code 12). 00 with address bits 7:6 = 11 is protect-enable (code 7). 11 with address FF is protect-clear (code 8). 01 is protect-write (code 9). 00 with address 00 is protect-disable (code 10). Any other combination issues nothing.
- R4: Enable, disable and protect-enable strobe within a few system cycles of their last address bit, with select still high.
- R5: Erase, write, erase-all, write-all, protect-clear, protect-write and protect-disable strobe only after select falls. Write and write-all carry the 16 data bits that follow the address, first bit as the most significant.
- R6: If select falls before every required bit has been shifted in, no strobe is issued.
- R7: After the last required bit, further clocks and data are ignored until the next start bit. A committed instruction keeps the address and data it was loaded with.
- R8: A read drives a 0 after the last address bit. It then drives the 16 bits of the word at the given address, most significant first, one bit per rising clock edge. While select stays high the next words follow, and the address wraps from the last word to word 0.
- R9: A protect-read drives a 0, then the 8 stored protect-address bits most significant first. The output enable drops at the next rising clock edge.
- R10: The output enable is low after reset, outside output and status phases, and within a few system cycles of select falling.
- R11: After a programming commit, raising select drives the output with enable high: 0 while busy is high and 1 when busy is low. A new start bit ends this status phase.
- R12: Every strobe lasts exactly one system clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock |
| cs_i | input | 1 | Select, active high |
| di_i | input | 1 | Serial data input |
| pre_i | input | 1 | Protect-select level used at decode |
| busy_i | input | 1 | Programming sequencer busy |
| rd_data_i | input | 16 | Memory word at rd_addr_o |
| prot_addr_i | input | 8 | Stored protect address |
| rd_addr_o | output | 8 | Memory read address |
| op_stb_o | output | 1 | One-cycle instruction strobe |
| op_code_o | output | 4 | Instruction code (see R2, R3) |
| op_addr_o | output | 8 | Instruction address field |
| op_data_o | output | 16 | Instruction data field |
| do_o | output | 1 | Serial data output value |
| do_oe_o | output | 1 | Serial data output enable |

## Verification
Each decode is driven once under both protect-select levels. This separates the opcode and address-field combinations that share an operation code but differ only in the top address bits or the select level. Write and write-all use asymmetric data patterns so that a reversed or shifted data field shows. Reads start two words below the top of the array, which covers the dummy bit, word-to-word streaming and the wrap in one pass. Truncated headers, truncated data and trailing clocks after completion separate commit-on-select-fall from commit-on-last-bit.

// File: rtl/mw_pkg.sv
package mw_pkg;

  typedef enum logic [3:0] {
    CMD_NONE  = 4'd0,
    CMD_EN    = 4'd1,
    CMD_DIS   = 4'd2,
    CMD_ERASE = 4'd3,
    CMD_WRITE = 4'd4,
    CMD_ERAL  = 4'd5,
    CMD_WRAL  = 4'd6,
    CMD_PEN   = 4'd7,
    CMD_PCLR  = 4'd8,
    CMD_PWR   = 4'd9,
    CMD_PDIS  = 4'd10,
    CMD_READ  = 4'd11,
    CMD_PREAD = 4'd12
  } cmd_e;

  typedef enum logic [1:0] {RX_IDLE, RX_HDR, RX_DATA, RX_DONE} rx_st_e;

  // opcode plus summary flags of the address field -> instruction
  function automatic cmd_e decode_cmd(input logic pre, input logic [1:0] op,
                                      input logic [1:0] top, input logic ones,
                                      input logic zeros);
    cmd_e c;
    c = CMD_NONE;
    if (!pre) begin
      case (op)
        2'b10: c = CMD_READ;
        2'b01: c = CMD_WRITE;
        2'b11: c = CMD_ERASE;
        default: begin
          case (top)
            2'b11:   c = CMD_EN;
            2'b10:   c = CMD_ERAL;
            2'b01:   c = CMD_WRAL;
            default: c = CMD_DIS;
          endcase
        end
      endcase
    end else begin
      case (op)
        2'b10: c = CMD_PREAD;
        2'b01: c = CMD_PWR;
        2'b11: c = ones ? CMD_PCLR : CMD_NONE;
        default: begin
          if (top == 2'b11)  c = CMD_PEN;
          else if (zeros)    c = CMD_PDIS;
          else               c = CMD_NONE;
        end
      endcase
    end
    return c;
  endfunction

  function automatic logic is_now(input cmd_e c);
    return (c == CMD_EN) || (c == CMD_DIS) || (c == CMD_PEN);
  endfunction

  function automatic logic has_data(input cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_WRAL);
  endfunction

  function automatic logic is_commit(input cmd_e c);
    return (c == CMD_ERASE) || (c == CMD_WRITE) || (c == CMD_ERAL) ||
           (c == CMD_WRAL)  || (c == CMD_PCLR)  || (c == CMD_PWR)  ||
           (c == CMD_PDIS);
  endfunction

  function automatic int unsigned wrap_inc(input int unsigned a,
                                           input int unsigned words);
    return (a + 1 >= words) ? 0 : a + 1;
  endfunction

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mw_rx.sv
module mw_rx import mw_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              cs_s,
  input  logic              cs_fall,
  input  logic              di_s,
  input  logic              pre_s,
  output logic              start_hit,
  output logic              hdr_done,
  output logic              data_done,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output rx_st_e            st_o
);
  localparam int OP_W    = 2;
  localparam int HDR_LEN = OP_W + ADDR_W;
  localparam int CNT_W   = $clog2(HDR_LEN + DATA_W + 1);

  rx_st_e             st;
  logic [CNT_W-1:0]   cnt;
  logic [HDR_LEN-1:0] hdr_sr;
  logic [HDR_LEN-1:0] hdr_nxt;
  logic [DATA_W-1:0]  dat_sr;
  cmd_e               cmd_q;
  cmd_e               cmd_now;

  assign hdr_nxt = {hdr_sr[HDR_LEN-2:0], di_s};
  assign cmd_now = decode_cmd(pre_s, hdr_nxt[HDR_LEN-1 -: OP_W],
                              hdr_nxt[ADDR_W-1 -: 2],
                              &hdr_nxt[ADDR_W-1:0], ~|hdr_nxt[ADDR_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      cnt       <= '0;
      hdr_sr    <= '0;
      dat_sr    <= '0;
      cmd_q     <= CMD_NONE;
      start_hit <= 1'b0;
      hdr_done  <= 1'b0;
      data_done <= 1'b0;
    end else begin
      start_hit <= 1'b0;
      hdr_done  <= 1'b0;
      data_done <= 1'b0;
      if (cs_fall) begin
        st  <= RX_IDLE;
        cnt <= '0;
      end else if (rise && cs_s) begin
        case (st)
          RX_IDLE: if (di_s) begin
            st        <= RX_HDR;
            cnt       <= '0;
            start_hit <= 1'b1;
          end
          RX_HDR: begin
            hdr_sr <= hdr_nxt;
            if (cnt == CNT_W'(HDR_LEN - 1)) begin
              hdr_done <= 1'b1;
              cmd_q    <= cmd_now;
              cnt      <= '0;
              st       <= has_data(cmd_now) ? RX_DATA : RX_DONE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            dat_sr <= {dat_sr[DATA_W-2:0], di_s};
            if (cnt == CNT_W'(DATA_W - 1)) begin
              data_done <= 1'b1;
              st        <= RX_DONE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign cmd_o  = cmd_q;
  assign addr_o = hdr_sr[ADDR_W-1:0];
  assign data_o = dat_sr;
  assign st_o   = st;
endmodule

// File: rtl/mw_tx.sv
module mw_tx import mw_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int WORDS  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              cs_fall,
  input  logic              go_rd,
  input  logic              go_pr,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [ADDR_W-1:0] prot_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              bit_o,
  output logic              act_o
);
  localparam int LEFT_W = $clog2(DATA_W);
  localparam int PAD    = DATA_W - ADDR_W;

  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] word_in;
  logic [LEFT_W-1:0] left;
  logic              need_load;
  logic              is_pr;
  logic [ADDR_W-1:0] addr_next;

  assign word_in   = is_pr ? {prot_i, {PAD{1'b0}}} : rd_data_i;
  assign addr_next = ADDR_W'(wrap_inc(32'(rd_addr_o), 32'(WORDS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_o     <= 1'b0;
      bit_o     <= 1'b0;
      sr        <= '0;
      left      <= '0;
      need_load <= 1'b0;
      is_pr     <= 1'b0;
      rd_addr_o <= '0;
    end else if (cs_fall) begin
      act_o     <= 1'b0;
      need_load <= 1'b0;
    end else if (go_rd || go_pr) begin
      act_o     <= 1'b1;
      bit_o     <= 1'b0;
      need_load <= 1'b1;
      is_pr     <= go_pr;
      rd_addr_o <= start_addr;
    end else if (rise && act_o) begin
      if (need_load || left == '0) begin
        if (is_pr && !need_load) begin
          act_o <= 1'b0;
        end else begin
          bit_o     <= word_in[DATA_W-1];
          sr        <= {word_in[DATA_W-2:0], 1'b0};
          left      <= is_pr ? LEFT_W'(ADDR_W - 1) : LEFT_W'(DATA_W - 1);
          need_load <= 1'b0;
          if (!is_pr) rd_addr_o <= addr_next;
        end
      end else begin
        bit_o <= sr[DATA_W-1];
        sr    <= {sr[DATA_W-2:0], 1'b0};
        left  <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mw_serial_front.sv
module mw_serial_front import mw_pkg::*; #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int WORDS       = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_i,
  input  logic              di_i,
  input  logic              pre_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [ADDR_W-1:0] prot_addr_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              op_stb_o,
  output logic [3:0]        op_code_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              do_o,
  output logic              do_oe_o
);
  logic [3:0] pin_s;
  logic s_sclk, s_cs, s_di, s_pre;
  logic sclk_q, cs_q;
  logic sclk_rise, cs_fall;

  mw_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk_i, cs_i, di_i, pre_i}), .q(pin_s)
  );
  assign {s_sclk, s_cs, s_di, s_pre} = pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      sclk_q <= s_sclk;
      cs_q   <= s_cs;
    end
  end

  // named events for the checker
  assign sclk_rise = s_sclk & ~sclk_q;
  assign cs_fall   = cs_q & ~s_cs;

  logic              start_hit, hdr_done, data_done;
  cmd_e              rx_cmd;
  logic [ADDR_W-1:0] rx_addr;
  logic [DATA_W-1:0] rx_data;
  rx_st_e            rx_st;

  mw_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rise(sclk_rise), .cs_s(s_cs),
    .cs_fall(cs_fall), .di_s(s_di), .pre_s(s_pre),
    .start_hit(start_hit), .hdr_done(hdr_done), .data_done(data_done),
    .cmd_o(rx_cmd), .addr_o(rx_addr), .data_o(rx_data), .st_o(rx_st)
  );

  logic go_rd, go_pr, tx_act, tx_bit;
  assign go_rd = hdr_done && (rx_cmd == CMD_READ);
  assign go_pr = hdr_done && (rx_cmd == CMD_PREAD);

  mw_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_tx (
    .clk(clk), .rst_n(rst_n), .rise(sclk_rise), .cs_fall(cs_fall),
    .go_rd(go_rd), .go_pr(go_pr), .start_addr(rx_addr),
    .rd_data_i(rd_data_i), .prot_i(prot_addr_i),
    .rd_addr_o(rd_addr_o), .bit_o(tx_bit), .act_o(tx_act)
  );

  logic              pend_vld;
  cmd_e              pend_cmd;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic              stat_arm;
  logic              stat_mode;
  logic              rx_loading;

  assign rx_loading = (rx_st == RX_HDR) || (rx_st == RX_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_stb_o  <= 1'b0;
      op_code_o <= '0;
      op_addr_o <= '0;
      op_data_o <= '0;
      pend_vld  <= 1'b0;
      pend_cmd  <= CMD_NONE;
      pend_addr <= '0;
      pend_data <= '0;
      stat_arm  <= 1'b0;
    end else begin
      op_stb_o <= 1'b0;
      if (hdr_done) begin
        pend_cmd  <= rx_cmd;
        pend_addr <= rx_addr;
        if (is_now(rx_cmd)) begin
          op_stb_o  <= 1'b1;
          op_code_o <= rx_cmd;
          op_addr_o <= rx_addr;
          op_data_o <= '0;
        end
        pend_vld <= is_commit(rx_cmd) && !has_data(rx_cmd);
      end
      if (data_done) begin
        pend_vld  <= 1'b1;
        pend_data <= rx_data;
      end
      if (start_hit) begin
        pend_vld <= 1'b0;
        stat_arm <= 1'b0;
      end
      if (cs_fall) begin
        pend_vld <= 1'b0;
        if (pend_vld && !rx_loading) begin
          op_stb_o  <= 1'b1;
          op_code_o <= pend_cmd;
          op_addr_o <= pend_addr;
          op_data_o <= has_data(pend_cmd) ? pend_data : '0;
          stat_arm  <= 1'b1;
        end
      end
    end
  end

  assign stat_mode = stat_arm & s_cs & ~tx_act;
  assign do_oe_o   = tx_act | stat_mode;
  assign do_o      = tx_act ? tx_bit : (stat_mode & ~busy_i);
endmodule

// File: rtl/mw_front_chk.sv
module mw_front_chk import mw_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_fall,
  input logic       s_cs,
  input logic       op_stb,
  input logic [3:0] op_code,
  input logic       do_oe,
  input logic       tx_act,
  input logic       tx_bit
);
  // R10
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (!do_oe || s_cs));

  // R12
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_stb |=> !op_stb);

  // R5
  commit_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_stb && is_commit(cmd_e'(op_code))) |-> $past(cs_fall));

  // R8
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_act) |-> !tx_bit);

  // R2
  stb_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_stb |-> (op_code != 4'd0));

  // R11
  status_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_oe && !tx_act) |-> s_cs);
endmodule

bind mw_serial_front mw_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .s_cs(s_cs),
  .op_stb(op_stb_o), .op_code(op_code_o), .do_oe(do_oe_o),
  .tx_act(tx_act), .tx_bit(tx_bit)
);

// File: tb/sim_mw_serial_front.sv
module sim_mw_serial_front;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs = 1'b0, di = 1'b0, pre = 1'b0, busy = 1'b0;
  logic [7:0]  prot = 8'hB6;
  logic [15:0] rd_data;
  logic [7:0]  rd_addr;
  logic        op_stb;
  logic [3:0]  op_code;
  logic [7:0]  op_addr;
  logic [15:0] op_data;
  logic        do_w, do_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] mem_f(input logic [7:0] a);
    return {a ^ 8'h3C, ~a};
  endfunction
  assign rd_data = mem_f(rd_addr);

  mw_serial_front u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_i(cs), .di_i(di),
    .pre_i(pre), .busy_i(busy), .rd_data_i(rd_data), .prot_addr_i(prot),
    .rd_addr_o(rd_addr), .op_stb_o(op_stb), .op_code_o(op_code),
    .op_addr_o(op_addr), .op_data_o(op_data), .do_o(do_w), .do_oe_o(do_oe)
  );

  int total = 0, bad = 0;
  int stb_cnt = 0, dbl = 0;
  logic prev_stb = 1'b0;
  logic [3:0]  l_code = '0;
  logic [7:0]  l_addr = '0;
  logic [15:0] l_data = '0;
  logic s_do, s_oe;

  always @(negedge clk) begin
    if (op_stb) begin
      stb_cnt++;
      l_code = op_code;
      l_addr = op_addr;
      l_data = op_data;
      if (prev_stb) dbl++;
    end
    prev_stb = op_stb;
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    di = b;
    repeat (HALF) @(posedge clk);
    @(negedge clk);
    s_do = do_w;
    s_oe = do_oe;
    sclk = 1'b1;
    repeat (HALF) @(posedge clk);
    #1 sclk = 1'b0;
  endtask

  task automatic send(input logic p, input logic [1:0] op, input logic [7:0] a);
    cs = 1'b1;
    pre = p;
    pulse(1'b1);
    pulse(op[1]);
    pulse(op[0]);
    for (int i = 7; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic send_data(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) pulse(d[i]);
  endtask

  task automatic drop_cs;
    cs = 1'b0;
    di = 1'b0;
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_eq("R10 reset oe", int'(do_oe), 0);
    check_eq("R12 reset strobe", int'(op_stb), 0);
  endtask

  task automatic t_start;
    int base;
    base = stb_cnt;
    cs = 1'b1;
    for (int i = 0; i < 6; i++) pulse(1'b0);
    drop_cs();
    for (int i = 0; i < 4; i++) pulse(1'b1);
    check_eq("R1 no start", stb_cnt, base);
    cs = 1'b1;
    pulse(1'b0);
    pulse(1'b0);
    send(1'b0, 2'b00, 8'hC0);
    check_eq("R1 start after zeros", stb_cnt, base + 1);
    check_eq("R1 code", int'(l_code), 1);
    drop_cs();
  endtask

  task automatic t_immediate;
    int base;
    base = stb_cnt;
    send(1'b0, 2'b00, 8'hC7);
    check_eq("R4 enable before fall", stb_cnt, base + 1);
    check_eq("R2 enable code", int'(l_code), 1);
    drop_cs();
    send(1'b0, 2'b00, 8'h00);
    check_eq("R4 disable before fall", stb_cnt, base + 2);
    check_eq("R2 disable code", int'(l_code), 2);
    drop_cs();
    check_eq("R4 no extra on fall", stb_cnt, base + 2);
  endtask

  task automatic t_commit;
    int base;
    base = stb_cnt;
    send(1'b0, 2'b01, 8'h35);
    send_data(16'hA5C3);
    check_eq("R5 write held", stb_cnt, base);
    drop_cs();
    check_eq("R5 write issued", stb_cnt, base + 1);
    check_eq("R2 write code", int'(l_code), 4);
    check_eq("R5 write addr", int'(l_addr), 'h35);
    check_eq("R5 write data", int'(l_data), 'hA5C3);
    send(1'b0, 2'b11, 8'h12);
    check_eq("R5 erase held", stb_cnt, base + 1);
    drop_cs();
    check_eq("R2 erase code", int'(l_code), 3);
    check_eq("R5 erase addr", int'(l_addr), 'h12);
    send(1'b0, 2'b00, 8'h80);
    drop_cs();
    check_eq("R2 erase-all code", int'(l_code), 5);
    send(1'b0, 2'b00, 8'h40);
    send_data(16'h1234);
    drop_cs();
    check_eq("R2 write-all code", int'(l_code), 6);
    check_eq("R5 write-all data", int'(l_data), 'h1234);
    check_eq("R5 commit count", stb_cnt, base + 4);
  endtask

  task automatic t_protect;
    int base;
    base = stb_cnt;
    send(1'b1, 2'b00, 8'hC5);
    check_eq("R3 protect-enable code", int'(l_code), 7);
    check_eq("R4 protect-enable early", stb_cnt, base + 1);
    drop_cs();
    send(1'b1, 2'b11, 8'hFF);
    drop_cs();
    check_eq("R3 protect-clear code", int'(l_code), 8);
    send(1'b1, 2'b01, 8'h40);
    drop_cs();
    check_eq("R3 protect-write code", int'(l_code), 9);
    check_eq("R3 protect-write addr", int'(l_addr), 'h40);
    send(1'b1, 2'b00, 8'h00);
    drop_cs();
    check_eq("R3 protect-disable code", int'(l_code), 10);
    send(1'b1, 2'b11, 8'h7F);
    drop_cs();
    send(1'b1, 2'b00, 8'h55);
    drop_cs();
    check_eq("R3 invalid ignored", stb_cnt, base + 4);
    pre = 1'b0;
  endtask

  task automatic t_discard;
    int base;
    base = stb_cnt;
    send(1'b0, 2'b01, 8'h22);
    for (int i = 0; i < 10; i++) pulse(i[0]);
    drop_cs();
    check_eq("R6 short data", stb_cnt, base);
    cs = 1'b1;
    pulse(1'b1);
    pulse(1'b1);
    pulse(1'b1);
    pulse(1'b0);
    drop_cs();
    check_eq("R6 short header", stb_cnt, base);
  endtask

  task automatic t_trailing;
    int base;
    base = stb_cnt;
    send(1'b0, 2'b11, 8'h2A);
    pulse(1'b1); pulse(1'b1); pulse(1'b0); pulse(1'b1); pulse(1'b1);
    drop_cs();
    check_eq("R7 one strobe", stb_cnt, base + 1);
    check_eq("R7 addr kept", int'(l_addr), 'h2A);
    check_eq("R7 code kept", int'(l_code), 3);
    send(1'b0, 2'b00, 8'hC0);
    pulse(1'b1); pulse(1'b0); pulse(1'b0); pulse(1'b1);
    drop_cs();
    check_eq("R7 enable no repeat", stb_cnt, base + 2);
  endtask

  task automatic t_read;
    logic [15:0] got [3];
    logic [7:0]  a;
    int oe_ok;
    oe_ok = 1;
    send(1'b0, 2'b10, 8'hFE);
    pulse(1'b0);
    check_eq("R8 dummy oe", int'(s_oe), 1);
    check_eq("R8 dummy zero", int'(s_do), 0);
    for (int w = 0; w < 3; w++) begin
      for (int i = 15; i >= 0; i--) begin
        pulse(1'b0);
        got[w][i] = s_do;
        if (!s_oe) oe_ok = 0;
      end
    end
    check_eq("R8 oe held", oe_ok, 1);
    a = 8'hFE;
    for (int w = 0; w < 3; w++) begin
      check_eq($sformatf("R8 word %0d", w), int'(got[w]), int'(mem_f(a)));
      a = a + 8'd1;
    end
    drop_cs();
    @(negedge clk);
    check_eq("R10 oe after read", int'(do_oe), 0);
  endtask

  task automatic t_pread;
    logic [7:0] got;
    prot = 8'hB6;
    send(1'b1, 2'b10, 8'h00);
    pulse(1'b0);
    check_eq("R9 dummy zero", int'(s_do), 0);
    check_eq("R9 dummy oe", int'(s_oe), 1);
    for (int i = 7; i >= 0; i--) begin
      pulse(1'b0);
      got[i] = s_do;
    end
    check_eq("R9 value", int'(got), 'hB6);
    pulse(1'b0);
    check_eq("R9 release", int'(s_oe), 0);
    drop_cs();
    pre = 1'b0;
  endtask

  task automatic t_status;
    send(1'b0, 2'b11, 8'h05);
    busy = 1'b1;
    drop_cs();
    cs = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    check_eq("R11 busy oe", int'(do_oe), 1);
    check_eq("R11 busy level", int'(do_w), 0);
    busy = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_eq("R11 ready level", int'(do_w), 1);
    drop_cs();
    @(negedge clk);
    check_eq("R10 oe after status", int'(do_oe), 0);
    cs = 1'b1;
    pulse(1'b1);
    pulse(1'b0);
    drop_cs();
    cs = 1'b1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    check_eq("R11 cleared by start", int'(do_oe), 0);
    drop_cs();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_start();
    t_immediate();
    t_commit();
    t_protect();
    t_discard();
    t_trailing();
    t_read();
    t_pread();
    t_status();
    check_eq("R12 single-cycle strobes", dbl, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule